// File: doc/BRIEF.md
# Safety-Gated Command Executor

This block carries out simple control commands that have already been decoded upstream. Each command arrives as a 4-bit code qualified by a one-cycle strobe. The block owns an active-low processor reset flag and a bank of active-low user flags, and it emits single-cycle reset pulses toward one link or toward every link at once. All of these outputs feed an external command interface.

Some commands can disturb the system and are treated as safety-critical: asserting the processor reset and any link reset. Before each one of these runs, a separate arm command must be received. Arming is one-shot: the arm bit clears as soon as a critical command is taken, so every critical action needs its own arm. A critical command that arrives while the block is disarmed has no effect on any output, and a one-cycle reject pulse reports it. Setting or clearing a user flag and releasing the processor reset are not critical. They run whatever the arm state is, and they leave that state alone.

Codes are grouped by their two upper bits. Group 0 holds no-operation (0x0), arm (0x1), processor reset assert (0x2) and processor reset release (0x3). Group 1 (0x4 to 0x7) resets a link, where the two lower bits pick the link and the value 3 means all links. Group 2 (0x8 to 0xB) asserts user flag n, where n is the two lower bits. Group 3 (0xC to 0xF) deasserts user flag n.

Top module: `safe_cmd_exec`

## Requirements
- R1: While rst_n is low and right after it is released, cpu_rst_n is 1, every usr_flag_n bit is 1, link_rst is 0 and cmd_reject is 0. The block starts disarmed, so a critical command issued before any arm is rejected.
- R2: Code 0x1 arms the block and changes no output. Arming again while already armed keeps the block armed.
- R3: Code 0x2 issued while armed drives cpu_rst_n to 0 on the clock edge that samples the command, and it disarms the block.
- R4: Code 0x3 drives cpu_rst_n to 1 whatever the arm state is, and it does not change the arm state.
- R5: Codes 0x8+n drive usr_flag_n[n] to 0 and codes 0xC+n drive it to 1. The other flags do not change, the arm state does not change, and no reject is raised.
- R6: Codes 0x4, 0x5 and 0x6 issued while armed set only link_rst bit 0, 1 or 2 for exactly one cycle, and they disarm the block.
- R7: Code 0x7 issued while armed sets all three link_rst bits for exactly one cycle, and it disarms the block.
- R8: Once a critical command has run, the next critical command is rejected unless a new arm command comes first.
- R9: A critical command received while disarmed leaves cpu_rst_n, usr_flag_n and link_rst unchanged. It raises cmd_reject for exactly the one cycle after it.
- R10: When cmd_valid is low, cmd_code is ignored: no output changes, link_rst and cmd_reject stay 0, and the arm state is kept.
- R11: Code 0x0 changes no output and does not consume an arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | One-cycle strobe that qualifies cmd_code |
| cmd_code | input | 4 | Decoded command code |
| cpu_rst_n | output | 1 | Processor reset flag, active low |
| usr_flag_n | output | NUM_FLAGS | User flags, active low |
| link_rst | output | NUM_LINKS | Single-cycle link reset pulses |
| cmd_reject | output | 1 | One-cycle pulse when a critical command is refused |

## Verification
The bench builds the block with its default values: four user flags and three links. With these values every code in the 4-bit space maps to a real action, and the all-links value of the link index falls exactly one past the last real link. This makes it possible to check that the all-links pulse and each single-link pulse stay apart. The stimulus walks the arm bit through every transition: arming twice, spending the arm on each kind of critical command, and being refused while disarmed. Between these steps it places non-critical commands and idle strobes, to show that they neither consume nor create an arm.

// File: rtl/sce_pkg.sv
// Package for the safety-gated command executor.
// Holds the command code layout: a 2-bit group and a 2-bit index.
// Assumes the code is exactly 4 bits wide.
package sce_pkg;
    localparam int CODE_W = 4;
    localparam int IDX_W  = 2;

    // Command group, taken from code bits [3:2]
    typedef enum logic [1:0] {
        GRP_MISC = 2'd0,
        GRP_LINK = 2'd1,
        GRP_FSET = 2'd2,
        GRP_FCLR = 2'd3
    } cmd_grp_e;

    // Index values used inside the misc group
    localparam logic [IDX_W-1:0] OP_NOP     = 2'd0;
    localparam logic [IDX_W-1:0] OP_ARM     = 2'd1;
    localparam logic [IDX_W-1:0] OP_CPU_ON  = 2'd2;
    localparam logic [IDX_W-1:0] OP_CPU_OFF = 2'd3;

    // Link index value that selects every link
    localparam logic [IDX_W-1:0] IDX_ALL = 2'd3;
endpackage

// File: rtl/sce_decode.sv
// Combinational command classifier.
// It splits a code into one-hot action requests and a criticality flag.
// Assumes NUM_LINKS <= 3 and NUM_FLAGS <= 4, so the 2-bit index covers them.
module sce_decode
    import sce_pkg::*;
#(
    parameter int NUM_LINKS = 3,
    parameter int NUM_FLAGS = 4
) (
    input  logic [CODE_W-1:0]    code,
    output logic                 is_arm,
    output logic                 is_crit,
    output logic                 cpu_on,
    output logic                 cpu_off,
    output logic [NUM_LINKS-1:0] link_mask,
    output logic [NUM_FLAGS-1:0] fset,
    output logic [NUM_FLAGS-1:0] fclr
);
    cmd_grp_e         grp;
    logic [IDX_W-1:0] idx;

    // Purpose: split the code into its group and index fields
    always_comb begin
        grp = cmd_grp_e'(code[CODE_W-1:IDX_W]);
        idx = code[IDX_W-1:0];
    end

    // Purpose: decode the misc group and decide criticality
    always_comb begin
        is_arm  = (grp == GRP_MISC) && (idx == OP_ARM);
        cpu_on  = (grp == GRP_MISC) && (idx == OP_CPU_ON);
        cpu_off = (grp == GRP_MISC) && (idx == OP_CPU_OFF);
        is_crit = cpu_on || (grp == GRP_LINK);
    end

    // One select bit per link; the all-links index sets every bit
    for (genvar l = 0; l < NUM_LINKS; l++) begin : g_link
        assign link_mask[l] = (grp == GRP_LINK) &&
                              ((idx == IDX_ALL) || (idx == IDX_W'(l)));
    end

    // One set request and one clear request per user flag
    for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
        assign fset[f] = (grp == GRP_FSET) && (idx == IDX_W'(f));
        assign fclr[f] = (grp == GRP_FCLR) && (idx == IDX_W'(f));
    end
endmodule

// File: rtl/sce_arm_gate.sv
// One-shot arm register and admission gate.
// An arm command sets the bit. Any critical command clears it, whether
// or not it ran. A critical command that arrives while disarmed is refused
// and reported one cycle later. Assumes a synchronous, active-low reset.
module sce_arm_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic valid,
    input  logic is_arm,
    input  logic is_crit,
    output logic exec_en,
    output logic reject,
    output logic armed
);
    logic armed_q;
    logic reject_q;

    // Purpose: admit non-critical commands always, critical ones only when armed
    always_comb begin
        exec_en = valid && (!is_crit || armed_q);
    end

    // Purpose: track the arm bit; it is consumed by any critical command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (valid && is_arm) begin
            armed_q <= 1'b1;
        end else if (valid && is_crit) begin
            armed_q <= 1'b0;
        end
    end

    // Purpose: raise a one-cycle reject for a critical command that was refused
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reject_q <= 1'b0;
        end else begin
            reject_q <= valid && is_crit && !armed_q;
        end
    end

    assign reject = reject_q;
    assign armed  = armed_q;
endmodule

// File: rtl/sce_outputs.sv
// Output register bank.
// Holds the processor reset flag and the user flags, which are level and
// active low. Drives the link reset pulses, which last one cycle. Requests
// take effect only when exec_en is high. Assumes a synchronous, active-low
// reset.
module sce_outputs #(
    parameter int NUM_LINKS = 3,
    parameter int NUM_FLAGS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 exec_en,
    input  logic                 cpu_on,
    input  logic                 cpu_off,
    input  logic [NUM_LINKS-1:0] link_mask,
    input  logic [NUM_FLAGS-1:0] fset,
    input  logic [NUM_FLAGS-1:0] fclr,
    output logic                 cpu_rst_n,
    output logic [NUM_FLAGS-1:0] flag_n,
    output logic [NUM_LINKS-1:0] link_rst
);
    logic                 cpu_q;
    logic [NUM_FLAGS-1:0] flag_q;
    logic [NUM_LINKS-1:0] link_q;

    // Purpose: hold the processor reset level (1 = released)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_q <= 1'b1;
        end else if (exec_en && cpu_on) begin
            cpu_q <= 1'b0;
        end else if (exec_en && cpu_off) begin
            cpu_q <= 1'b1;
        end
    end

    // One register per user flag
    for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
        // Purpose: hold one user flag level (1 = deasserted)
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag_q[f] <= 1'b1;
            end else if (exec_en && fset[f]) begin
                flag_q[f] <= 1'b0;
            end else if (exec_en && fclr[f]) begin
                flag_q[f] <= 1'b1;
            end
        end
    end

    // Purpose: issue link reset pulses that last one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            link_q <= '0;
        end else begin
            link_q <= exec_en ? link_mask : '0;
        end
    end

    assign cpu_rst_n = cpu_q;
    assign flag_n    = flag_q;
    assign link_rst  = link_q;
endmodule

// File: rtl/safe_cmd_exec.sv
// Top of the safety-gated command executor.
// Connects the decoder, the arm gate and the output bank. Every output
// is registered, so a command sampled on one edge shows up right after it.
// Assumes a synchronous, active-low reset and commands already decoded upstream.
module safe_cmd_exec
    import sce_pkg::*;
#(
    parameter int NUM_LINKS = 3,
    parameter int NUM_FLAGS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic [CODE_W-1:0]    cmd_code,
    output logic                 cpu_rst_n,
    output logic [NUM_FLAGS-1:0] usr_flag_n,
    output logic [NUM_LINKS-1:0] link_rst,
    output logic                 cmd_reject
);
    logic                 is_arm;
    logic                 is_crit;
    logic                 cpu_on;
    logic                 cpu_off;
    logic [NUM_LINKS-1:0] link_mask;
    logic [NUM_FLAGS-1:0] fset;
    logic [NUM_FLAGS-1:0] fclr;
    logic                 exec_en;
    logic                 arm_state;

    sce_decode #(
        .NUM_LINKS(NUM_LINKS),
        .NUM_FLAGS(NUM_FLAGS)
    ) u_decode (
        .code     (cmd_code),
        .is_arm   (is_arm),
        .is_crit  (is_crit),
        .cpu_on   (cpu_on),
        .cpu_off  (cpu_off),
        .link_mask(link_mask),
        .fset     (fset),
        .fclr     (fclr)
    );

    sce_arm_gate u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .valid  (cmd_valid),
        .is_arm (is_arm),
        .is_crit(is_crit),
        .exec_en(exec_en),
        .reject (cmd_reject),
        .armed  (arm_state)
    );

    sce_outputs #(
        .NUM_LINKS(NUM_LINKS),
        .NUM_FLAGS(NUM_FLAGS)
    ) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .exec_en  (exec_en),
        .cpu_on   (cpu_on),
        .cpu_off  (cpu_off),
        .link_mask(link_mask),
        .fset     (fset),
        .fclr     (fclr),
        .cpu_rst_n(cpu_rst_n),
        .flag_n   (usr_flag_n),
        .link_rst (link_rst)
    );
endmodule

// File: rtl/sce_checker.sv
// Assertion checker for safe_cmd_exec, attached to it through bind.
// Assumes the code layout given in sce_pkg.
module sce_checker #(
    parameter int NUM_LINKS = 3,
    parameter int NUM_FLAGS = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cmd_valid,
    input logic [3:0]           cmd_code,
    input logic                 cpu_rst_n,
    input logic [NUM_FLAGS-1:0] usr_flag_n,
    input logic [NUM_LINKS-1:0] link_rst,
    input logic                 cmd_reject,
    input logic                 armed
);
    logic crit_in;
    assign crit_in = (cmd_code == 4'h2) || (cmd_code[3:2] == 2'b01);

    // R2: an arm command leaves the block armed
    a_r2_arm_sets: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_code == 4'h1 |=> armed);

    // R3: the processor reset can only fall if the block was armed
    a_r3_cpu_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_rst_n) |-> $past(armed));

    // R6: a link pulse never lasts two cycles
    a_r6_link_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        link_rst != '0 |=> link_rst == '0);

    // R7: link pulses target one link or every link
    a_r7_link_shape: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(link_rst) || (&link_rst));

    // R8: any critical command consumes the arm
    a_r8_disarm_after_crit: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && crit_in |=> !armed);

    // R9: a refused command is reported and has no effect
    a_r9_refused_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && crit_in && !armed |=>
            cmd_reject && link_rst == '0 && $stable(cpu_rst_n) && $stable(usr_flag_n));

    // R10: an idle cycle changes nothing
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !cmd_reject && link_rst == '0 &&
            $stable(cpu_rst_n) && $stable(usr_flag_n) && armed == $past(armed));
endmodule

bind safe_cmd_exec sce_checker #(
    .NUM_LINKS(NUM_LINKS),
    .NUM_FLAGS(NUM_FLAGS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .cpu_rst_n (cpu_rst_n),
    .usr_flag_n(usr_flag_n),
    .link_rst  (link_rst),
    .cmd_reject(cmd_reject),
    .armed     (arm_state)
);

// File: tb/tb_safe_cmd_exec.sv
// Scoreboard bench for safe_cmd_exec.
module tb_safe_cmd_exec;
    localparam int NL = 3;
    localparam int NF = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [3:0]    cmd_code = 4'h0;
    logic          cpu_rst_n;
    logic [NF-1:0] usr_flag_n;
    logic [NL-1:0] link_rst;
    logic          cmd_reject;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        logic          cpu;
        logic [NF-1:0] flg;
        logic [NL-1:0] lnk;
        logic          rej;
        string         tag;
    } exp_t;

    exp_t q[$];

    // Reference state, built from the requirements
    logic          m_armed = 1'b0;
    logic          m_cpu   = 1'b1;
    logic [NF-1:0] m_flg   = '1;

    always #5 clk = ~clk;

    safe_cmd_exec #(.NUM_LINKS(NL), .NUM_FLAGS(NF)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cpu_rst_n(cpu_rst_n), .usr_flag_n(usr_flag_n),
        .link_rst(link_rst), .cmd_reject(cmd_reject)
    );

    // Drive one cycle of stimulus and push the expected outputs
    task automatic issue(input logic v, input logic [3:0] c, input string tag);
        exp_t e;
        logic crit;
        @(negedge clk);
        cmd_valid = v;
        cmd_code  = c;
        e.lnk = '0;
        e.rej = 1'b0;
        if (v) begin
            crit = (c == 4'h2) || (c[3:2] == 2'b01);
            if (crit && !m_armed) begin
                e.rej = 1'b1;
            end else if (crit) begin
                m_armed = 1'b0;
                if (c == 4'h2) m_cpu = 1'b0;
                else if (c[1:0] == 2'd3) e.lnk = '1;
                else e.lnk = NL'(1) << c[1:0];
            end else begin
                if (c == 4'h1) m_armed = 1'b1;
                if (c == 4'h3) m_cpu = 1'b1;
                if (c[3:2] == 2'b10) m_flg[c[1:0]] = 1'b0;
                if (c[3:2] == 2'b11) m_flg[c[1:0]] = 1'b1;
            end
        end
        e.cpu = m_cpu;
        e.flg = m_flg;
        e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: compare each result just after the edge that produces it
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (cpu_rst_n !== e.cpu || usr_flag_n !== e.flg ||
                    link_rst !== e.lnk || cmd_reject !== e.rej) begin
                    errors++;
                    $display("FAIL %s: got cpu=%b flg=%b lnk=%b rej=%b exp cpu=%b flg=%b lnk=%b rej=%b",
                             e.tag, cpu_rst_n, usr_flag_n, link_rst, cmd_reject,
                             e.cpu, e.flg, e.lnk, e.rej);
                end
            end
        end
    end

    // Watchdog
    initial begin
        #2000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got hung run exp completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state, with a strobe driven that must be ignored
        cmd_valid = 1'b1;
        cmd_code  = 4'h1;
        repeat (3) @(posedge clk);
        #2;
        checks++;
        if (cpu_rst_n !== 1'b1 || usr_flag_n !== '1 || link_rst !== '0 || cmd_reject !== 1'b0) begin
            errors++;
            $display("FAIL R1: got cpu=%b flg=%b lnk=%b rej=%b exp 1 1111 000 0",
                     cpu_rst_n, usr_flag_n, link_rst, cmd_reject);
        end
        @(negedge clk);
        cmd_valid = 1'b0;
        rst_n = 1'b1;

        issue(1'b0, 4'h2, "R10 idle with critical code");
        issue(1'b1, 4'h2, "R1 disarmed after reset");
        issue(1'b1, 4'h7, "R9 all-links refused");
        issue(1'b1, 4'h1, "R2 arm");
        issue(1'b1, 4'h1, "R2 re-arm");
        issue(1'b1, 4'h0, "R11 nop");
        issue(1'b1, 4'h3, "R4 release while armed");
        issue(1'b1, 4'h8, "R5 set flag0");
        issue(1'b1, 4'h2, "R3 cpu assert");
        issue(1'b1, 4'h2, "R8 second critical refused");
        issue(1'b1, 4'h3, "R4 release while disarmed");
        issue(1'b1, 4'h1, "R2 arm");
        issue(1'b1, 4'h5, "R6 link1");
        issue(1'b0, 4'h0, "R6 pulse ends");
        issue(1'b1, 4'h6, "R8 link2 refused");
        issue(1'b1, 4'h1, "R2 arm");
        issue(1'b1, 4'h4, "R6 link0");
        issue(1'b1, 4'h1, "R2 arm");
        issue(1'b1, 4'h6, "R6 link2");
        issue(1'b1, 4'h1, "R2 arm");
        issue(1'b1, 4'h7, "R7 all links");
        issue(1'b0, 4'h0, "R7 pulse ends");
        issue(1'b1, 4'hA, "R5 set flag2");
        issue(1'b1, 4'hB, "R5 set flag3");
        issue(1'b1, 4'hC, "R5 clear flag0");
        issue(1'b1, 4'hE, "R5 clear flag2");
        issue(1'b0, 4'h1, "R10 idle arm ignored");
        issue(1'b1, 4'h4, "R10 still disarmed");
        issue(1'b1, 4'h1, "R2 arm");
        issue(1'b1, 4'h9, "R5 flag set keeps arm");
        issue(1'b1, 4'h0, "R11 nop keeps arm");
        issue(1'b1, 4'h2, "R11 arm survived");
        issue(1'b1, 4'hD, "R5 clear flag1");
        issue(1'b0, 4'h0, "R10 final idle");

        @(negedge clk);
        cmd_valid = 1'b0;
        while (q.size() > 0) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule